// File: doc/BRIEF.md
# Physical Register Rename Stage

This block gives every register write in an out-of-order core a fresh physical name. A lookup table, indexed by architectural register number, records which physical register holds the newest value of each architectural register. A pool of unused physical registers, kept as a first-in first-out queue, supplies the new names.

On every rename cycle the block translates two source register numbers through the lookup table. If the instruction writes a register, the block takes the oldest entry of the pool as the new name for the destination and points the table entry at it. It also outputs the physical register that the destination displaced. The core keeps that displaced name with the instruction. When the instruction retires, the core sends the name back on the release port and the block appends it to the pool. Recovery of the table after a mispredicted branch and the physical register file itself are outside this block.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i translates to physical register i for every i below ARCH_REGS, and the pool holds physical registers ARCH_REGS to PHYS_REGS-1 in ascending order, with ARCH_REGS at the front.
- R2: `ren_phys_a` and `ren_phys_b` are the lookup-table entries for `ren_src_a` and `ren_src_b` as they stand before this cycle's update. A source that equals the instruction's own destination therefore sees the old name.
- R3: When the pool is not empty, `ren_phys_dst` shows the front entry of the pool. An accepted instruction with a destination removes that entry, so successive allocations follow pool order.
- R4: From the cycle after an accepted allocation, lookups of the destination register return the newly allocated physical register.
- R5: `ren_phys_old` is the lookup-table entry of `ren_dst` before this cycle's update, and it is the name the instruction displaces.
- R6: `ren_stall` is 1 when `ren_valid` and `ren_has_dst` are both 1 and the pool is empty. A stalled instruction changes neither the lookup table nor the pool.
- R7: A release (`commit_valid`=1) appends `commit_phys` to the back of the pool at the clock edge. Released names are handed out again in the order they were released.
- R8: A release and an allocation in the same cycle both take effect. The pool size stays the same, and the released name appears after the entries already queued.
- R9: An accepted instruction with `ren_has_dst`=0 leaves the lookup table and the pool unchanged.
- R10: `ren_stall` is 0 whenever `ren_valid` is 0 or `ren_has_dst` is 0, even when the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src_a | input | $clog2(ARCH_REGS) | First source architectural register |
| ren_src_b | input | $clog2(ARCH_REGS) | Second source architectural register |
| ren_has_dst | input | 1 | The instruction writes a register |
| ren_dst | input | $clog2(ARCH_REGS) | Destination architectural register |
| ren_stall | output | 1 | The instruction cannot be accepted this cycle |
| ren_phys_a | output | $clog2(PHYS_REGS) | Translated first source |
| ren_phys_b | output | $clog2(PHYS_REGS) | Translated second source |
| ren_phys_dst | output | $clog2(PHYS_REGS) | Newly allocated physical destination |
| ren_phys_old | output | $clog2(PHYS_REGS) | Displaced physical register of the destination |
| commit_valid | input | 1 | A displaced register is released at retirement |
| commit_phys | input | $clog2(PHYS_REGS) | Physical register being released |

## Verification
The checker watches several rules on every cycle. A stall appears only for a valid instruction that needs a destination. An allocated name becomes visible on the following cycle, both as the source translation and as the displaced name. Cycles that allocate nothing leave every translation unchanged, and a cycle that both allocates and releases keeps the pool size the same. The bench's scenarios cover what a single-cycle property cannot express: the identity mapping after reset, the exact order in which pool entries come out, the return of released names after the pool has drained, and the case where a release arrives while an instruction is stalled.

// File: rtl/rn_pkg.sv
// rn_pkg: default sizes shared by the rename stage and its checker.
// Assumes PHYS_REGS - ARCH_REGS is at least 2.
package rn_pkg;
    localparam int unsigned DEF_ARCH_REGS = 32;
    localparam int unsigned DEF_PHYS_REGS = 64;
endpackage

// File: rtl/rn_map_table.sv
// rn_map_table: one physical name per architectural register, with three
// combinational read ports and one write port that updates at the clock edge.
// Assumes the reads see the contents from before any write in the same cycle.
module rn_map_table #(
    parameter int unsigned ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_d_idx,
    output logic [PW-1:0] rd_a_phys,
    output logic [PW-1:0] rd_b_phys,
    output logic [PW-1:0] rd_d_phys,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_phys
);
    logic [PW-1:0] entry [ARCH_REGS];

    // Identity mapping at reset; a single entry is overwritten on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) entry[i] <= PW'(i);
        end else if (wr_en) begin
            entry[wr_idx] <= wr_phys;
        end
    end

    assign rd_a_phys = entry[rd_a_idx];
    assign rd_b_phys = entry[rd_b_idx];
    assign rd_d_phys = entry[rd_d_idx];
endmodule

// File: rtl/rn_free_fifo.sv
// rn_free_fifo: circular queue of unused physical register names. At reset it
// is full of BASE, BASE+1, ... BASE+DEPTH-1. A push and a pop may occur in the
// same cycle. Assumes the caller never pushes into a full queue or pops from
// an empty one.
module rn_free_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned PW    = 6,
    parameter int unsigned BASE  = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [PW-1:0]    push_data,
    output logic [PW-1:0]    head_data,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [PW-1:0]    slot [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    // Advance a pointer by one with wrap-around at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage: preload the spare names at reset; write released names at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) slot[j] <= PW'(BASE + j);
        end else if (push) begin
            slot[tail_q] <= push_data;
        end
    end

    // Pointers and occupancy; a simultaneous push and pop leave the count unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CNT_W'(DEPTH);
        end else begin
            if (pop)  head_q <= bump(head_q);
            if (push) tail_q <= bump(tail_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_data = slot[head_q];
    assign empty     = (count_q == '0);
    assign count     = count_q;
endmodule

// File: rtl/reg_rename_unit.sv
// reg_rename_unit: translates sources through the lookup table and, for
// instructions that write a register, hands out a fresh physical name from the
// free pool and reports the name it displaces. Retirement releases displaced
// names back into the pool. Assumes the core releases each displaced name
// exactly once.
module reg_rename_unit #(
    parameter int unsigned ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
    localparam int unsigned AW    = $clog2(ARCH_REGS),
    localparam int unsigned PW    = $clog2(PHYS_REGS),
    localparam int unsigned SPARE = PHYS_REGS - ARCH_REGS,
    localparam int unsigned CNT_W = $clog2(SPARE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic          ren_has_dst,
    input  logic [AW-1:0] ren_dst,
    output logic          ren_stall,
    output logic [PW-1:0] ren_phys_a,
    output logic [PW-1:0] ren_phys_b,
    output logic [PW-1:0] ren_phys_dst,
    output logic [PW-1:0] ren_phys_old,
    input  logic          commit_valid,
    input  logic [PW-1:0] commit_phys
);
    logic             pool_empty;
    logic             alloc;
    logic [CNT_W-1:0] free_cnt;

    // Hold the instruction only when it needs a name and none is free.
    always_comb begin
        ren_stall = ren_valid && ren_has_dst && pool_empty;
        alloc     = ren_valid && ren_has_dst && !pool_empty;
    end

    rn_map_table #(
        .ARCH_REGS(ARCH_REGS),
        .PHYS_REGS(PHYS_REGS)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (ren_src_a),
        .rd_b_idx  (ren_src_b),
        .rd_d_idx  (ren_dst),
        .rd_a_phys (ren_phys_a),
        .rd_b_phys (ren_phys_b),
        .rd_d_phys (ren_phys_old),
        .wr_en     (alloc),
        .wr_idx    (ren_dst),
        .wr_phys   (ren_phys_dst)
    );

    rn_free_fifo #(
        .DEPTH (SPARE),
        .PW    (PW),
        .BASE  (ARCH_REGS)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (alloc),
        .push      (commit_valid),
        .push_data (commit_phys),
        .head_data (ren_phys_dst),
        .empty     (pool_empty),
        .count     (free_cnt)
    );
endmodule

// File: rtl/rn_checker.sv
// rn_checker: cycle-by-cycle properties of the rename stage, bound to every
// instance of reg_rename_unit. Checks begin one cycle after reset is released.
module rn_checker #(
    parameter int unsigned ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
    localparam int unsigned AW    = $clog2(ARCH_REGS),
    localparam int unsigned PW    = $clog2(PHYS_REGS),
    localparam int unsigned SPARE = PHYS_REGS - ARCH_REGS,
    localparam int unsigned CNT_W = $clog2(SPARE + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ren_valid,
    input logic [AW-1:0]    ren_src_a,
    input logic             ren_has_dst,
    input logic [AW-1:0]    ren_dst,
    input logic             ren_stall,
    input logic [PW-1:0]    ren_phys_a,
    input logic [PW-1:0]    ren_phys_dst,
    input logic [PW-1:0]    ren_phys_old,
    input logic             commit_valid,
    input logic [CNT_W-1:0] free_cnt
);
    logic primed;
    logic takes;

    // Enable checks that look back one cycle only after a reset-free cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assign takes = ren_valid && ren_has_dst && !ren_stall;

    // R10
    stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ren_stall |-> (ren_valid && ren_has_dst));

    // R6
    stall_keeps_pool_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (ren_stall && !commit_valid) |=> (free_cnt == '0));

    // R3
    fresh_name_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        takes |-> (ren_phys_dst != ren_phys_old));

    // R4
    map_update_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(takes) && ren_src_a == $past(ren_dst)) |-> (ren_phys_a == $past(ren_phys_dst)));

    // R5
    old_name_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(takes) && ren_dst == $past(ren_dst)) |-> (ren_phys_old == $past(ren_phys_dst)));

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (!$past(takes) && ren_src_a == $past(ren_src_a)) |-> (ren_phys_a == $past(ren_phys_a)));

    // R8
    swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (takes && commit_valid) |=> $stable(free_cnt));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (commit_valid && !takes) |-> (free_cnt < CNT_W'(SPARE)));
endmodule

bind reg_rename_unit rn_checker #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS)
) u_rn_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_src_a    (ren_src_a),
    .ren_has_dst  (ren_has_dst),
    .ren_dst      (ren_dst),
    .ren_stall    (ren_stall),
    .ren_phys_a   (ren_phys_a),
    .ren_phys_dst (ren_phys_dst),
    .ren_phys_old (ren_phys_old),
    .commit_valid (commit_valid),
    .free_cnt     (free_cnt)
);

// File: tb/reg_rename_unit_test.sv
// reg_rename_unit_test: scoreboard bench. The driver computes expected outputs
// from a reference model of the table and pool, and queues them. The monitor
// compares them with the design's outputs in the middle of each cycle.
module reg_rename_unit_test;
    localparam int ARCH = 32;
    localparam int PHYS = 64;
    localparam int AW   = $clog2(ARCH);
    localparam int PW   = $clog2(PHYS);

    typedef struct {
        logic          stall;
        logic [PW-1:0] pa, pb, pdst, pold;
        logic          has_alloc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0, ren_has_dst = 1'b0, commit_valid = 1'b0;
    logic [AW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic [PW-1:0] commit_phys = '0;
    logic          ren_stall;
    logic [PW-1:0] ren_phys_a, ren_phys_b, ren_phys_dst, ren_phys_old;

    int checks = 0;
    int fails  = 0;

    logic [PW-1:0] model_map [ARCH];
    logic [PW-1:0] model_free [$];
    logic [PW-1:0] retire_q [$];
    exp_t          exp_q [$];

    always #5 clk = ~clk;

    reg_rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_has_dst(ren_has_dst), .ren_dst(ren_dst), .ren_stall(ren_stall),
        .ren_phys_a(ren_phys_a), .ren_phys_b(ren_phys_b),
        .ren_phys_dst(ren_phys_dst), .ren_phys_old(ren_phys_old),
        .commit_valid(commit_valid), .commit_phys(commit_phys)
    );

    task automatic compare(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Drive one cycle, queue the expected outputs, then advance the model.
    task automatic step(input logic v, input int sa, input int sb, input logic hd,
                        input int d, input logic rel, input string tag);
        exp_t e;
        @(negedge clk);
        ren_valid   = v;
        ren_src_a   = AW'(sa);
        ren_src_b   = AW'(sb);
        ren_has_dst = hd;
        ren_dst     = AW'(d);
        commit_valid = rel && (retire_q.size() > 0);
        commit_phys  = commit_valid ? retire_q.pop_front() : '0;
        e.stall = v && hd && (model_free.size() == 0);
        e.pa    = model_map[sa];
        e.pb    = model_map[sb];
        e.pold  = model_map[d];
        e.has_alloc = v && hd && !e.stall;
        e.pdst  = e.has_alloc ? model_free[0] : '0;
        e.tag   = tag;
        exp_q.push_back(e);
        if (e.has_alloc) begin
            model_map[d] = model_free.pop_front();
            retire_q.push_back(e.pold);
        end
        if (commit_valid) model_free.push_back(commit_phys);
    endtask

    // Monitor: pop one expectation per driven cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                compare(e.tag, "stall", int'(ren_stall), int'(e.stall));
                compare(e.tag, "phys_a", int'(ren_phys_a), int'(e.pa));
                compare(e.tag, "phys_b", int'(ren_phys_b), int'(e.pb));
                if (e.has_alloc) begin
                    compare(e.tag, "phys_dst", int'(ren_phys_dst), int'(e.pdst));
                    compare(e.tag, "phys_old", int'(ren_phys_old), int'(e.pold));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < ARCH; i++) model_map[i] = PW'(i);
        for (int j = ARCH; j < PHYS; j++) model_free.push_back(PW'(j));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: identity translations after reset
        step(0, 0, 31, 0, 0, 0, "R1");
        step(0, 7, 12, 0, 0, 0, "R1");
        // R10: no stall without a valid instruction
        step(0, 1, 2, 1, 1, 0, "R10");
        // R2: a source equal to the destination sees the old name; first name is 32
        step(1, 3, 5, 1, 3, 0, "R2");
        // R4 and R5: the update is visible next cycle
        step(1, 3, 3, 1, 3, 0, "R4_R5");
        // R9: no destination, nothing changes
        step(1, 4, 3, 0, 3, 0, "R9");
        step(1, 3, 4, 1, 6, 0, "R9");
        // R3: drain the pool in order
        for (int k = 0; model_free.size() > 0; k++)
            step(1, (k * 5) % ARCH, (k + 1) % ARCH, 1, (k * 7) % ARCH, 0, "R3");
        // R6: stall when empty, nothing changes
        step(1, 9, 2, 1, 9, 0, "R6");
        step(0, 9, 2, 0, 0, 0, "R6");
        // R10: no stall without a destination even when empty
        step(1, 9, 9, 0, 9, 0, "R10");
        // R6: a release during a stall does not unstall that cycle
        step(1, 2, 2, 1, 2, 1, "R6");
        // R7: the released name comes back out
        step(1, 2, 2, 1, 2, 0, "R7");
        step(0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 1, "R7");
        step(1, 5, 6, 1, 5, 0, "R7");
        step(1, 5, 6, 1, 6, 0, "R7");
        // R8: simultaneous allocation and release
        step(0, 0, 0, 0, 0, 1, "R8");
        step(1, 8, 8, 1, 8, 1, "R8");
        step(1, 8, 8, 1, 8, 1, "R8");
        step(1, 8, 11, 1, 11, 0, "R8");
        for (int k = 0; k < 60; k++)
            step(1, (k * 3) % ARCH, (k * 11) % ARCH, (k % 3) != 0, (k * 13) % ARCH,
                 (k % 2) == 0, "R8");
        step(0, 0, 0, 0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule